// File: doc/BRIEF.md
# Programmable Interval Timer with Modulo Reload

This block is a small timer peripheral clocked from the 4.194304 MHz system clock. A 16-bit free-running prescaler advances on every clock, and its upper byte can be read as a divider value. An 8-bit count register advances at one of four rates, each taken from a tap of the prescaler. When the count passes 0xFF it does not wrap to zero. It takes the value held in a modulo register and raises a one-cycle interrupt request.

Software reaches four byte-wide registers through a simple bus. The bus has a 2-bit address, a write strobe, write data and a combinational read-data path. A control register sets whether the timer runs and which rate it uses. The interrupt output is meant for an interrupt controller outside this block.

Top module: `prog_timer`

## Requirements
- R1: Address 3 is the control register. Bit 2 is the run enable (1 = run) and bits 1:0 are the rate code. Bits above 2 are not stored and read back as zero.
- R2: Address 0 reads bits 15:8 of the 16-bit prescaler, which advances by one on every clock. Any write to address 0 clears all 16 bits, whatever the data.
- R3: The rate codes select 4.096 kHz (00), 262.144 kHz (01), 65.536 kHz (10) and 16.384 kHz (11). With the 4.194304 MHz clock these are one count every 1024, 16, 64 and 256 clocks.
- R4: Address 1 is the count register. It advances by one on each falling edge of the selected prescaler bit ANDed with the run enable, so stopping the timer while that bit is high gives one final increment.
- R5: A bus write to the count register in the same cycle as an increment or a reload wins. The written value is stored, and no interrupt is raised for that cycle.
- R6: Address 2 is the modulo register. When the count advances from 0xFF it is loaded with the modulo value held before that clock edge.
- R7: The interrupt output is high for exactly one cycle. That cycle is the one in which the count register first shows the reloaded value.
- R8: After reset the prescaler, count, modulo and control registers are zero and the interrupt output is low.
- R9: While the run enable is 0 and no count write happens, the count register holds its value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, 4.194304 MHz nominal |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 2 | Register select: 0 divider, 1 count, 2 modulo, 3 control |
| bus_wr | input | 1 | Write strobe for the addressed register |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data of the addressed register (combinational) |
| irq_o | output | 1 | One-cycle timer interrupt request |

## Verification
A wrong prescaler value shows on the divider read within 256 clocks. It also moves every later count increment, so the count read disagrees from the first missed or extra tick onward. A faulty tick detector or rate decode shifts the count by at least one within one period of the selected tap, which is at most 1024 clocks. A wrong reload or a lost write-priority shows on the very next read of the count and on the interrupt pin in the same cycle. The bench therefore compares every register read and the interrupt pin on every clock against its own reference model.

// File: rtl/prog_timer_pkg.sv
package prog_timer_pkg;

   typedef enum logic [1:0] {
      SEL_DIV = 2'd0,
      SEL_CNT = 2'd1,
      SEL_MOD = 2'd2,
      SEL_CTL = 2'd3
   } tmr_reg_e;

   localparam int CTL_W = 3;

   typedef struct packed {
      logic       run;
      logic [1:0] rate;
   } tmr_ctl_t;

endpackage

// File: rtl/tmr_prescaler.sv
module tmr_prescaler #(
   parameter int PRESC_W = 16
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               clr_i,
   output logic [PRESC_W-1:0] value_o
);

   if (PRESC_W < 2) begin : g_bad_w
      $error("tmr_prescaler: PRESC_W must be at least 2");
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     value_o <= '0;
      else if (clr_i) value_o <= '0;
      else            value_o <= value_o + 1'b1;
   end

   AST_DIV_CLEARED: assert property (@(posedge clk) disable iff (!rst_n)
      clr_i |=> value_o == '0); // R2

   AST_DIV_ADVANCES: assert property (@(posedge clk) disable iff (!rst_n)
      !clr_i |=> value_o == PRESC_W'($past(value_o) + 1'b1)); // R2

endmodule

// File: rtl/tmr_tick_gen.sv
module tmr_tick_gen #(
   parameter int PRESC_W = 16,
   parameter int TAP_00  = 9,
   parameter int TAP_01  = 3,
   parameter int TAP_10  = 5,
   parameter int TAP_11  = 7
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [PRESC_W-1:0] presc_i,
   input  logic               run_i,
   input  logic [1:0]         rate_i,
   output logic               tick_o
);

   localparam int N_RATES = 4;

   logic [N_RATES-1:0] tap_bits;
   logic               src;
   logic               src_q;

   for (genvar g = 0; g < N_RATES; g++) begin : g_tap
      localparam int TP = (g == 0) ? TAP_00 :
                          (g == 1) ? TAP_01 :
                          (g == 2) ? TAP_10 : TAP_11;
      if (TP < 0 || TP >= PRESC_W) begin : g_bad_tap
         $error("tmr_tick_gen: tap index outside the prescaler");
      end
      assign tap_bits[g] = presc_i[TP];
   end

   assign src    = tap_bits[rate_i] & run_i;
   assign tick_o = src_q & ~src;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) src_q <= 1'b0;
      else        src_q <= src;
   end

   AST_TICK_ISOLATED: assert property (@(posedge clk) disable iff (!rst_n)
      tick_o |=> !tick_o); // R4

endmodule

// File: rtl/tmr_count_unit.sv
module tmr_count_unit #(
   parameter int DATA_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              tick_i,
   input  logic              wr_cnt_i,
   input  logic              wr_mod_i,
   input  logic [DATA_W-1:0] wdata_i,
   output logic [DATA_W-1:0] cnt_o,
   output logic [DATA_W-1:0] mod_o,
   output logic              irq_o
);

   if (DATA_W < 2) begin : g_bad_w
      $error("tmr_count_unit: DATA_W must be at least 2");
   end

   logic at_top;
   logic wrap;

   assign at_top = (cnt_o == {DATA_W{1'b1}});
   assign wrap   = tick_i & ~wr_cnt_i & at_top;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_o <= '0;
         irq_o <= 1'b0;
      end else begin
         irq_o <= wrap;
         if (wr_cnt_i)    cnt_o <= wdata_i;
         else if (wrap)   cnt_o <= mod_o;
         else if (tick_i) cnt_o <= cnt_o + 1'b1;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)        mod_o <= '0;
      else if (wr_mod_i) mod_o <= wdata_i;
   end

   AST_RELOAD_FROM_MOD: assert property (@(posedge clk) disable iff (!rst_n)
      irq_o |-> cnt_o == $past(mod_o)); // R6

   AST_IRQ_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
      irq_o |=> !irq_o); // R7

   AST_WRITE_WINS: assert property (@(posedge clk) disable iff (!rst_n)
      wr_cnt_i |=> (cnt_o == $past(wdata_i)) && !irq_o); // R5

   AST_HOLD_NO_TICK: assert property (@(posedge clk) disable iff (!rst_n)
      (!tick_i && !wr_cnt_i) |=> $stable(cnt_o)); // R9

   AST_STEP_BY_ONE: assert property (@(posedge clk) disable iff (!rst_n)
      (tick_i && !wr_cnt_i && !at_top) |=> cnt_o == DATA_W'($past(cnt_o) + 1'b1)); // R4

endmodule

// File: rtl/prog_timer.sv
module prog_timer
   import prog_timer_pkg::*;
#(
   parameter int DATA_W  = 8,
   parameter int PRESC_W = 16,
   parameter int TAP_00  = 9,
   parameter int TAP_01  = 3,
   parameter int TAP_10  = 5,
   parameter int TAP_11  = 7
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [1:0]        bus_addr,
   input  logic              bus_wr,
   input  logic [DATA_W-1:0] bus_wdata,
   output logic [DATA_W-1:0] bus_rdata,
   output logic              irq_o
);

   localparam int DIV_LO = PRESC_W - DATA_W;

   if (DATA_W < CTL_W) begin : g_bad_data
      $error("prog_timer: DATA_W too small for the control field");
   end
   if (PRESC_W < DATA_W) begin : g_bad_presc
      $error("prog_timer: PRESC_W must not be narrower than DATA_W");
   end

   tmr_reg_e          sel;
   logic              wr_div, wr_cnt, wr_mod, wr_ctl;
   tmr_ctl_t          ctl_q;
   logic [PRESC_W-1:0] presc;
   logic              tick;
   logic [DATA_W-1:0] cnt, modv;

   assign sel    = tmr_reg_e'(bus_addr);
   assign wr_div = bus_wr && (sel == SEL_DIV);
   assign wr_cnt = bus_wr && (sel == SEL_CNT);
   assign wr_mod = bus_wr && (sel == SEL_MOD);
   assign wr_ctl = bus_wr && (sel == SEL_CTL);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      ctl_q <= '0;
      else if (wr_ctl) ctl_q <= tmr_ctl_t'(bus_wdata[CTL_W-1:0]);
   end

   tmr_prescaler #(.PRESC_W(PRESC_W)) u_presc (
      .clk     (clk),
      .rst_n   (rst_n),
      .clr_i   (wr_div),
      .value_o (presc)
   );

   tmr_tick_gen #(
      .PRESC_W (PRESC_W),
      .TAP_00  (TAP_00),
      .TAP_01  (TAP_01),
      .TAP_10  (TAP_10),
      .TAP_11  (TAP_11)
   ) u_tick (
      .clk     (clk),
      .rst_n   (rst_n),
      .presc_i (presc),
      .run_i   (ctl_q.run),
      .rate_i  (ctl_q.rate),
      .tick_o  (tick)
   );

   tmr_count_unit #(.DATA_W(DATA_W)) u_count (
      .clk      (clk),
      .rst_n    (rst_n),
      .tick_i   (tick),
      .wr_cnt_i (wr_cnt),
      .wr_mod_i (wr_mod),
      .wdata_i  (bus_wdata),
      .cnt_o    (cnt),
      .mod_o    (modv),
      .irq_o    (irq_o)
   );

   always_comb begin
      unique case (sel)
         SEL_DIV: bus_rdata = presc[PRESC_W-1:DIV_LO];
         SEL_CNT: bus_rdata = cnt;
         SEL_MOD: bus_rdata = modv;
         SEL_CTL: bus_rdata = {{(DATA_W-CTL_W){1'b0}}, ctl_q};
         default: bus_rdata = '0;
      endcase
   end

   AST_CTL_UPPER_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      (sel == SEL_CTL) |-> bus_rdata[DATA_W-1:CTL_W] == '0); // R1

   AST_IRQ_AFTER_RESET: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(rst_n) |-> !irq_o); // R8

endmodule

// File: tb/tb_prog_timer.sv
`timescale 1ns/1ps
module tb_prog_timer;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [1:0] addr = 2'd0;
   logic       wr = 1'b0;
   logic [7:0] wdata = 8'd0;
   logic [7:0] rdata;
   logic       irq;

   int n_checks = 0;
   int n_err    = 0;
   bit cmp_on   = 1'b0;

   always #2.5 clk = ~clk;

   prog_timer dut (
      .clk(clk), .rst_n(rst_n), .bus_addr(addr), .bus_wr(wr),
      .bus_wdata(wdata), .bus_rdata(rdata), .irq_o(irq)
   );

   // reference model state
   int m_presc, m_cnt, m_mod, m_ctl;
   bit m_srcq, m_irq;

   function automatic int tap_for(int code);
      int freq;
      case (code & 3)
         0: freq = 4096;
         1: freq = 262144;
         2: freq = 65536;
         default: freq = 16384;
      endcase
      return $clog2(4194304 / freq) - 1;
   endfunction

   always @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         m_presc = 0; m_cnt = 0; m_mod = 0; m_ctl = 0; m_srcq = 0; m_irq = 0;
      end else begin
         bit src_now, tick;
         int old_mod;
         src_now = ((m_presc >> tap_for(m_ctl)) & 1) == 1 && ((m_ctl >> 2) & 1) == 1;
         tick    = m_srcq && !src_now;
         m_srcq  = src_now;
         old_mod = m_mod;
         m_irq   = 0;
         if (wr && addr == 2'd1) m_cnt = wdata;
         else if (tick) begin
            if (m_cnt == 255) begin m_cnt = old_mod; m_irq = 1; end
            else m_cnt = m_cnt + 1;
         end
         if (wr && addr == 2'd2) m_mod = wdata;
         if (wr && addr == 2'd3) m_ctl = wdata & 7;
         if (wr && addr == 2'd0) m_presc = 0;
         else m_presc = (m_presc + 1) % 65536;
      end
   end

   task automatic chk(string req, int act, int exp);
      n_checks++;
      if (act != exp) begin
         n_err++;
         $display("FAIL %s: act %0h exp %0h at %0t", req, act, exp, $time);
      end
   endtask

   function automatic int exp_read(int a);
      case (a)
         0: return (m_presc >> 8) & 255;
         1: return m_cnt;
         2: return m_mod;
         default: return m_ctl;
      endcase
   endfunction

   // per-cycle comparison against the model
   always @(negedge clk) begin
      if (rst_n && cmp_on) begin
         chk("R7 irq pin", int'(irq), int'(m_irq));
         case (addr)
            2'd0: chk("R2 divider read", int'(rdata), exp_read(0));
            2'd1: chk("R4 count read", int'(rdata), exp_read(1));
            2'd2: chk("R6 modulo read", int'(rdata), exp_read(2));
            default: chk("R1 control read", int'(rdata), exp_read(3));
         endcase
      end
   end

   task automatic wr_reg(int a, int d);
      addr = 2'(a); wdata = 8'(d); wr = 1'b1;
      @(negedge clk); #0.5;
      wr = 1'b0;
   endtask

   task automatic peek(int a, output int v);
      addr = 2'(a); #0.3;
      v = int'(rdata);
   endtask

   task automatic idle(int n);
      for (int i = 0; i < n; i++) begin
         addr = 2'(i % 4);
         @(negedge clk); #0.5;
      end
   endtask

   task automatic summary;
      $display("Simulation finished: %0d checks, %0d errors", n_checks, n_err);
   endtask

   initial begin
      #(200000 * 5);
      n_err++;
      $display("FAIL watchdog R8: act timeout exp end of run");
      summary();
      $finish;
   end

   initial begin
      int v, c0;
      repeat (3) @(negedge clk);
      #0.5 rst_n = 1'b1;
      // R8 reset state
      peek(0, v); chk("R8 divider at reset", v, 0);
      peek(1, v); chk("R8 count at reset", v, 0);
      peek(2, v); chk("R8 modulo at reset", v, 0);
      peek(3, v); chk("R8 control at reset", v, 0);
      chk("R8 irq at reset", int'(irq), 0);
      @(negedge clk); #0.5;
      cmp_on = 1'b1;

      // R1 control write keeps only three bits
      wr_reg(3, 8'hFD);
      peek(3, v); chk("R1 control upper bits dropped", v, 5);

      // R6 / R7 reload and pulse at rate 01
      wr_reg(2, 8'hF0);
      wr_reg(1, 8'hFE);
      begin
         bit seen = 0;
         for (int i = 0; i < 200 && !seen; i++) begin
            addr = 2'd1;
            @(negedge clk); #0.2;
            if (irq) begin
               seen = 1;
               chk("R6 count equals modulo at reload", int'(rdata), 8'hF0);
            end
         end
         chk("R7 irq seen", int'(seen), 1);
         @(negedge clk); #0.2;
         chk("R7 irq lasts one cycle", int'(irq), 0);
         #0.3;
      end
      idle(800);

      // R2 divider write clears prescaler
      idle(300);
      wr_reg(0, 8'h5A);
      peek(0, v); chk("R2 divider cleared by write", v, 0);

      // R5 write collides with increment, then with overflow
      while (!(m_presc % 16 == 0 && m_srcq)) begin @(negedge clk); #0.5; end
      wr_reg(1, 8'hFF);
      peek(1, v); chk("R5 write beats increment", v, 8'hFF);
      while (!(m_presc % 16 == 0 && m_srcq)) begin @(negedge clk); #0.5; end
      wr_reg(1, 8'h33);
      peek(1, v); chk("R5 write beats reload", v, 8'h33);
      chk("R5 no irq on overridden reload", int'(irq), 0);

      // R4 stopping while tap bit high gives one last step; R9 hold afterwards
      while (m_presc % 16 != 10) begin @(negedge clk); #0.5; end
      peek(1, c0);
      wr_reg(3, 8'h01);
      @(negedge clk); #0.5; @(negedge clk); #0.5;
      peek(1, v); chk("R4 final step on stop", v, (c0 + 1) % 256);
      idle(400);
      peek(1, v); chk("R9 count holds while stopped", v, (c0 + 1) % 256);

      // R3 rate 10: one step per 64 clocks
      wr_reg(3, 8'h06);
      wr_reg(0, 0);
      addr = 2'd1; wdata = 8'd0; wr = 1'b1;
      @(negedge clk); #0.5; wr = 1'b0;
      repeat (639) begin @(negedge clk); end
      #0.5; peek(1, v); chk("R3 rate 10 after 639 clocks", v, 9);
      @(negedge clk); #0.5;
      peek(1, v); chk("R3 rate 10 after 640 clocks", v, 10);

      // R3 the remaining rates, with overflow and reload
      wr_reg(2, 8'hFD);
      wr_reg(1, 8'hFC);
      wr_reg(3, 8'h04); idle(9000);
      wr_reg(3, 8'h07); idle(3000);
      wr_reg(2, 8'h10);
      wr_reg(3, 8'h05); idle(6000);
      peek(3, v); chk("R1 control readback", v, 5);

      cmp_on = 1'b0;
      summary();
      $finish;
   end

endmodule